// File: doc/BRIEF.md
# Command-Framed SPI Register Target

This block is the device end of a command-framed serial link. It is an SPI mode 0 target, oversampled by the system clock, that takes an eight-byte command header from the host. It checks the chip identifier and a 7-bit CRC in that header. It then runs one single-byte or burst access against an internal byte-wide register store. Replies go back on MISO at fixed byte positions in the same frame. A single read returns its data in byte 6, the acknowledge code comes in byte 7, and burst read data starts at byte 8.

The header is laid out as follows:

| Byte | Contents |
|------|----------|
| 0 | start bit in bit 7, chip identifier in bits 6:0 |
| 1 | burst flag (bit 7), write flag (bit 6), fixed-address flag (bit 5), address bits 10:6 (bits 4:0) |
| 2 | address bits 5:0 (bits 7:2), length bits 13:12 (bits 1:0) |
| 3 | length bits 11:4 for a burst, or the write data for a single write |
| 4 | length bits 3:0 (bits 7:4), CRC bits 6:3 (bits 3:0) |
| 5 | CRC bits 2:0 (bits 7:5), then five 1 bits |

Bytes 6 and 7 are turnaround bytes. The length field holds the beat count minus one.

SCK high and low phases must each last at least SYNC_STAGES+4 system clocks. The controller has five states:

- `ST_IDLE`: chip select is high.
- `ST_HDR`: header bytes 0 to 5 are being received.
- `ST_TURN`: bytes 6 and 7 of a validated frame.
- `ST_BURST`: the data beats.
- `ST_DRAIN`: the rest of the frame is ignored.

The transitions are:

- IDLE→HDR when chip select falls.
- HDR→TURN at the end of byte 5 if the header is valid.
- HDR→DRAIN at the end of byte 5 if the header is not valid.
- TURN→BURST at the end of byte 7 for a burst.
- TURN→DRAIN at the end of byte 7 for a single access.
- BURST→DRAIN after the last beat.
- Any state→IDLE when chip select rises.

Top module: `cmdspi_target`

## Requirements
- R1: The address is assembled as {byte1[4:0], byte2[7:2]}, and the burst length-minus-one as {byte2[1:0], byte3, byte4[7:4]}. Byte1 bit 7 selects burst, bit 6 selects write, and bit 5 selects fixed address.
- R2: The CRC is computed MSB first over the first 36 header bits. It uses a zero seed and polynomial mask 0x09: shift left, and XOR in 0x09 when the old bit 6 differs from the input bit. It is compared with {byte4[3:0], byte5[7:5]}.
- R3: When byte0[6:0] equals CHIP_ID and the CRC matches, MISO carries 0x47 during byte 7. Otherwise MISO carries 0x00 during byte 7.
- R4: A valid single write stores byte 3 at the address at the end of byte 5. A valid single read returns the stored byte on MISO during byte 6.
- R5: Burst data occupies bytes 8 through 8+length. MOSI bytes after the last beat write nothing, and MISO is 0x00 in the byte after the last read beat.
- R6: With the fixed flag set, every burst beat uses the header address.
- R7: With the fixed flag clear, the address rises by one after each burst beat.
- R8: On a chip identifier or CRC mismatch, the target performs no write and drives 0x00 until chip select rises.
- R9: Chip select rising at any point clears the byte and bit counters and the header state. A frame cut short performs no access.
- R10: MISO is 0 during reset, while chip select is high, and through header bytes 0 to 5. It changes only after a synchronised SCK falling edge or on chip select rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data |

## Verification
The bench goes after the header field split by placing addresses with bits set on both sides of the byte1/byte2 boundary. It also uses a 20-beat burst whose length needs byte 3. A decoder that misaligned the fields would write the wrong cell or the wrong number of beats.

It sends frames with one flipped CRC bit and frames with a foreign identifier, then reads the target cell back. A design that acknowledged them or let the write through would show 0x47 or corrupted data.

Fixed-mode bursts are checked against an untouched neighbour cell, and an extra MOSI byte is sent after a one-beat burst. A step error or a length overrun would change the neighbour. A frame aborted inside the header must leave the register unchanged, and the next frame must still decode correctly.

// File: rtl/cmdspi_pkg.sv
`timescale 1ns/1ps
package cmdspi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_TURN,
        ST_BURST,
        ST_DRAIN
    } cspi_state_e;

    localparam int          ADDR_W        = 11;
    localparam int          LEN_W         = 14;
    localparam int          HDR_CRC_BITS  = 36;
    localparam logic [6:0]  CRC_POLY      = 7'h09;
    localparam logic [7:0]  ACK_CODE      = 8'h47;
    localparam logic [3:0]  LAST_HDR_BYTE = 4'd5;
    localparam logic [3:0]  DATA_BYTE0    = 4'd8;
endpackage

// File: rtl/cmdspi_sync.sv
`timescale 1ns/1ps
module cmdspi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_q,
    output logic mosi_q
);
    logic [STAGES-1:0] sck_p, cs_p, mosi_p;
    logic              sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p  <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
            sck_d  <= 1'b0;
        end else begin
            sck_p  <= {sck_p[STAGES-2:0], sck_i};
            cs_p   <= {cs_p[STAGES-2:0], cs_n_i};
            mosi_p <= {mosi_p[STAGES-2:0], mosi_i};
            sck_d  <= sck_p[STAGES-1];
        end
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_d;
    assign sck_fall = ~sck_p[STAGES-1] & sck_d;
    assign cs_q     = cs_p[STAGES-1];
    assign mosi_q   = mosi_p[STAGES-1];
endmodule

// File: rtl/cmdspi_crc7.sv
`timescale 1ns/1ps
module cmdspi_crc7 #(
    parameter logic [6:0] POLY = 7'h09
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       bit_i,
    output logic [6:0] crc_o
);
    logic fb;
    assign fb = crc_o[6] ^ bit_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc_o <= '0;
        else if (clr)
            crc_o <= '0;
        else if (en)
            crc_o <= {crc_o[5:0], 1'b0} ^ (fb ? POLY : 7'h00);
    end
endmodule

// File: rtl/cmdspi_regmem.sv
`timescale 1ns/1ps
module cmdspi_regmem #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 2 ** AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        if (re)
            rdata <= mem[addr];
    end
endmodule

// File: rtl/cmdspi_target.sv
`timescale 1ns/1ps
module cmdspi_target
    import cmdspi_pkg::*;
#(
    parameter logic [6:0] CHIP_ID     = 7'h2A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    localparam logic [LEN_W:0] ONE_BEAT = (LEN_W+1)'(1);

    cspi_state_e      state, state_n;
    logic             sck_rise, sck_fall, cs_q, mosi_q;
    logic [2:0]       bit_cnt;
    logic [3:0]       byte_idx;
    logic [6:0]       rx_sr;
    logic [7:0]       rx_byte;
    logic             byte_done;
    logic             id_ok;
    logic [7:0]       hdr1, hdr2, hdr3, hdr4;
    logic [6:0]       crc_val, rx_crc;
    logic             crc_en, hdr_valid;
    logic             f_burst, f_wr, f_fix;
    logic [ADDR_W-1:0] f_addr, cur_addr, mem_addr;
    logic [LEN_W-1:0] f_len;
    logic [LEN_W:0]   beats_left;
    logic             op_burst, op_wr, op_fix;
    logic             mem_we, mem_re;
    logic [7:0]       mem_wdata, mem_rdata;
    logic [7:0]       tx_sr, tx_const, tx_next;
    logic             tx_from_mem;

    cmdspi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_q(cs_q), .mosi_q(mosi_q)
    );

    assign crc_en = sck_rise && !cs_q && ({byte_idx, bit_cnt} < 7'(HDR_CRC_BITS));

    cmdspi_crc7 #(.POLY(CRC_POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(cs_q), .en(crc_en), .bit_i(mosi_q), .crc_o(crc_val)
    );

    cmdspi_regmem #(.AW(ADDR_W), .DW(8)) u_mem (
        .clk(clk), .we(mem_we), .re(mem_re), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
    );

    // Header field decode
    assign rx_byte   = {rx_sr, mosi_q};
    assign byte_done = sck_rise && !cs_q && (bit_cnt == 3'd7);
    assign f_burst   = hdr1[7];
    assign f_wr      = hdr1[6];
    assign f_fix     = hdr1[5];
    assign f_addr    = {hdr1[4:0], hdr2[7:2]};
    assign f_len     = {hdr2[1:0], hdr3, hdr4[7:4]};
    assign rx_crc    = {hdr4[3:0], rx_byte[7:5]};
    assign hdr_valid = id_ok && (rx_crc == crc_val);
    assign tx_next   = tx_from_mem ? mem_rdata : tx_const;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        if (cs_q) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_n = ST_HDR;
                ST_HDR:   if (byte_done && byte_idx == LAST_HDR_BYTE)
                              state_n = hdr_valid ? ST_TURN : ST_DRAIN;
                ST_TURN:  if (byte_done && byte_idx == 4'd7)
                              state_n = op_burst ? ST_BURST : ST_DRAIN;
                ST_BURST: if (byte_done && beats_left == ONE_BEAT)
                              state_n = ST_DRAIN;
                ST_DRAIN: state_n = ST_DRAIN;
                default:  state_n = ST_IDLE;
            endcase
        end
    end

    // Register-store port
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = cur_addr;
        mem_wdata = rx_byte;
        if (byte_done) begin
            unique case (state)
                ST_HDR: if (byte_idx == LAST_HDR_BYTE && hdr_valid && !f_burst) begin
                    mem_addr  = f_addr;
                    mem_we    = f_wr;
                    mem_re    = !f_wr;
                    mem_wdata = hdr3;
                end
                ST_TURN:  mem_re = (byte_idx == 4'd7) && op_burst && !op_wr;
                ST_BURST: begin
                    if (op_wr) begin
                        mem_we = 1'b1;
                    end else if (beats_left > ONE_BEAT) begin
                        mem_re   = 1'b1;
                        mem_addr = op_fix ? cur_addr : cur_addr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Counters, header capture and MISO drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0; byte_idx <= '0; rx_sr <= '0; id_ok <= 1'b0;
            hdr1 <= '0; hdr2 <= '0; hdr3 <= '0; hdr4 <= '0;
            op_burst <= 1'b0; op_wr <= 1'b0; op_fix <= 1'b0;
            cur_addr <= '0; beats_left <= '0;
            tx_sr <= '0; tx_const <= '0; tx_from_mem <= 1'b0;
            spi_miso <= 1'b0;
        end else if (cs_q) begin
            bit_cnt <= '0; byte_idx <= '0; id_ok <= 1'b0;
            tx_sr <= '0; tx_const <= '0; tx_from_mem <= 1'b0;
            spi_miso <= 1'b0;
        end else begin
            if (sck_rise) begin
                rx_sr   <= rx_byte[6:0];
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (byte_done) begin
                if (byte_idx != DATA_BYTE0)
                    byte_idx <= byte_idx + 4'd1;
                case (byte_idx)
                    4'd0: id_ok <= (rx_byte[6:0] == CHIP_ID);
                    4'd1: hdr1 <= rx_byte;
                    4'd2: hdr2 <= rx_byte;
                    4'd3: hdr3 <= rx_byte;
                    4'd4: hdr4 <= rx_byte;
                    default: ;
                endcase
                tx_const    <= 8'h00;
                tx_from_mem <= 1'b0;
                if (state == ST_HDR && byte_idx == LAST_HDR_BYTE && hdr_valid) begin
                    op_burst    <= f_burst;
                    op_wr       <= f_wr;
                    op_fix      <= f_fix;
                    cur_addr    <= f_addr;
                    beats_left  <= {1'b0, f_len} + ONE_BEAT;
                    tx_from_mem <= !f_burst && !f_wr;
                end
                if (state == ST_TURN && byte_idx == 4'd6)
                    tx_const <= ACK_CODE;
                if (state == ST_TURN && byte_idx == 4'd7)
                    tx_from_mem <= op_burst && !op_wr;
                if (state == ST_BURST) begin
                    beats_left  <= beats_left - ONE_BEAT;
                    tx_from_mem <= !op_wr && (beats_left > ONE_BEAT);
                    if (!op_fix)
                        cur_addr <= cur_addr + 1'b1;
                end
            end
            if (sck_fall)
                tx_sr <= (bit_cnt == 3'd0) ? tx_next : {tx_sr[6:0], 1'b0};
            spi_miso <= tx_sr[7];
        end
    end
endmodule

// File: rtl/cmdspi_target_chk.sv
`timescale 1ns/1ps
module cmdspi_target_chk
    import cmdspi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_q,
    input logic              sck_fall,
    input logic              byte_done,
    input logic              spi_miso,
    input cspi_state_e       state,
    input logic              mem_we,
    input logic              mem_re,
    input logic              op_fix,
    input logic              id_ok,
    input logic [3:0]        byte_idx,
    input logic [ADDR_W-1:0] cur_addr
);
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |=> !spi_miso); // R10
    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_miso) |-> ($past(sck_fall, 2) || $past(cs_q))); // R10
    AST_NO_PORT_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R4
    AST_FIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && op_fix) |=> $stable(cur_addr)); // R6
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && !op_fix && byte_done) |=> cur_addr == ADDR_W'($past(cur_addr) + 1)); // R7
    AST_WR_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (byte_idx >= 4'd5 && !cs_q)); // R8
    AST_ACK_NEEDS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN) |-> id_ok); // R3
endmodule

bind cmdspi_target cmdspi_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .sck_fall(sck_fall), .byte_done(byte_done),
    .spi_miso(spi_miso), .state(state), .mem_we(mem_we), .mem_re(mem_re),
    .op_fix(op_fix), .id_ok(id_ok), .byte_idx(byte_idx), .cur_addr(cur_addr)
);

// File: tb/cmdspi_target_tb_top.sv
`timescale 1ns/1ps
module cmdspi_target_tb_top;
    localparam logic [6:0] ID   = 7'h2A;
    localparam int         HALF = 6;

    typedef logic [7:0] bq_t[$];

    logic clk = 1'b0, rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso;

    always #2.5 clk = ~clk;

    cmdspi_target #(.CHIP_ID(ID)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int drv_xfer = 0, mon_xfer = 0, mon_pos = 0, mon_bits = 0;
    logic [7:0] mon_sr = '0;

    // Scoreboard queues: transfer number, byte position, value, tag
    int         ex_x[$];
    int         ex_p[$];
    logic [7:0] ex_v[$];
    string      ex_t[$];

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic expect_b(input int pos, input logic [7:0] v, input string t);
        ex_x.push_back(drv_xfer + 1);
        ex_p.push_back(pos);
        ex_v.push_back(v);
        ex_t.push_back(t);
    endtask

    // Monitor
    initial forever begin
        @(negedge spi_cs_n);
        mon_xfer++;
        mon_pos  = 0;
        mon_bits = 0;
    end

    initial forever begin
        @(posedge spi_sck);
        if (!spi_cs_n) begin
            mon_sr = {mon_sr[6:0], spi_miso};
            mon_bits++;
            if (mon_bits == 8) begin
                mon_bits = 0;
                while (ex_x.size() > 0 && ex_x[0] == mon_xfer && ex_p[0] == mon_pos) begin
                    chk(mon_sr, ex_v[0], ex_t[0]);
                    void'(ex_x.pop_front());
                    void'(ex_p.pop_front());
                    void'(ex_v.pop_front());
                    void'(ex_t.pop_front());
                end
                mon_pos++;
            end
        end
    end

    function automatic logic [6:0] crc36(input logic [35:0] v);
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = 35; i >= 0; i--) begin
            fb = c[6] ^ v[i];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic bq_t hdr(input logic [6:0] id, input logic burst, input logic wr,
                                input logic fix, input logic [10:0] a, input logic [13:0] lm1,
                                input logic [7:0] d, input bit bad);
        logic [7:0] b0, b1, b2, b3;
        logic [3:0] b4h;
        logic [6:0] c;
        bq_t q;
        b0  = {1'b1, id};
        b1  = {burst, wr, fix, a[10:6]};
        b2  = {a[5:0], burst ? lm1[13:12] : 2'b00};
        b3  = burst ? lm1[11:4] : d;
        b4h = burst ? lm1[3:0] : 4'h0;
        c   = crc36({b0, b1, b2, b3, b4h});
        if (bad) c[0] = ~c[0];
        q.push_back(b0); q.push_back(b1); q.push_back(b2); q.push_back(b3);
        q.push_back({b4h, c[6:3]}); q.push_back({c[2:0], 5'b11111});
        q.push_back(8'hFF); q.push_back(8'hFF);
        return q;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input bq_t b, input int keep);
        wait_clk(1);
        spi_cs_n = 1'b0;
        drv_xfer++;
        wait_clk(4);
        for (int k = 0; k < keep; k++) begin
            for (int i = 7; i >= 0; i--) begin
                spi_mosi = b[k][i];
                wait_clk(HALF);
                spi_sck = 1'b1;
                wait_clk(HALF);
                spi_sck = 1'b0;
            end
        end
        wait_clk(4);
        spi_cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic s_write(input logic [10:0] a, input logic [7:0] d, input string t,
                           input logic [6:0] id = ID, input bit bad = 1'b0, input int keep = 8);
        bq_t q;
        bit  ok;
        q  = hdr(id, 1'b0, 1'b1, 1'b0, a, 14'd0, d, bad);
        ok = (id == ID) && !bad;
        if (keep == 8) begin
            expect_b(6, 8'h00, t);
            expect_b(7, ok ? 8'h47 : 8'h00, t);
        end
        xfer(q, keep);
    endtask

    task automatic s_read(input logic [10:0] a, input logic [7:0] expd, input string t);
        bq_t q;
        q = hdr(ID, 1'b0, 1'b0, 1'b0, a, 14'd0, 8'h00, 1'b0);
        expect_b(0, 8'h00, "R10 header byte 0 quiet");
        expect_b(6, expd, t);
        expect_b(7, 8'h47, t);
        xfer(q, 8);
    endtask

    task automatic b_write(input logic [10:0] a, input logic fix, input bq_t d,
                           input logic [7:0] extra, input string t);
        bq_t q;
        q = hdr(ID, 1'b1, 1'b1, fix, a, 14'(d.size() - 1), 8'h00, 1'b0);
        foreach (d[i]) q.push_back(d[i]);
        q.push_back(extra);
        expect_b(7, 8'h47, t);
        xfer(q, q.size());
    endtask

    task automatic b_read(input logic [10:0] a, input logic fix, input bq_t e, input string t);
        bq_t q;
        q = hdr(ID, 1'b1, 1'b0, fix, a, 14'(e.size() - 1), 8'h00, 1'b0);
        for (int i = 0; i <= e.size(); i++) q.push_back(8'hFF);
        expect_b(7, 8'h47, t);
        foreach (e[i]) expect_b(8 + i, e[i], t);
        expect_b(8 + e.size(), 8'h00, "R5 byte after last read beat");
        xfer(q, q.size());
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        bq_t d;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        chk({7'd0, spi_miso}, 8'h00, "R10 MISO low after reset");

        // Address straddling the byte1/byte2 split
        s_write(11'h0C3, 8'hA5, "R1 R3 single write acknowledged");
        s_read(11'h0C3, 8'hA5, "R4 single read data in byte 6");

        // Corrupt CRC, then foreign identifier
        s_write(11'h0C3, 8'h11, "R2 flipped CRC bit refused", ID, 1'b1);
        s_read(11'h0C3, 8'hA5, "R8 CRC-failed write dropped");
        s_write(11'h0C3, 8'h22, "R3 foreign chip id refused", 7'h15, 1'b0);
        s_read(11'h0C3, 8'hA5, "R8 id-failed write dropped");

        // Fixed-address burst write with a sentinel neighbour
        s_write(11'h021, 8'h5A, "R4 sentinel write");
        d = {}; d.push_back(8'h31); d.push_back(8'h32); d.push_back(8'h33);
        b_write(11'h020, 1'b1, d, 8'hFF, "R6 fixed burst write");
        s_read(11'h020, 8'h33, "R6 fixed burst keeps one address");
        s_read(11'h021, 8'h5A, "R6 neighbour untouched");

        // Incrementing burst write and read
        d = {}; d.push_back(8'h10); d.push_back(8'h20); d.push_back(8'h30); d.push_back(8'h40);
        b_write(11'h040, 1'b0, d, 8'hFF, "R7 incrementing burst write");
        b_read(11'h040, 1'b0, d, "R7 R5 incrementing burst read");

        d = {}; d.push_back(8'h20); d.push_back(8'h20); d.push_back(8'h20);
        b_read(11'h041, 1'b1, d, "R6 fixed burst read repeats one cell");

        // Single-beat burst with a surplus MOSI byte
        s_write(11'h061, 8'h99, "R4 sentinel write");
        d = {}; d.push_back(8'h77);
        b_write(11'h060, 1'b0, d, 8'hEE, "R5 one-beat burst write");
        s_read(11'h060, 8'h77, "R5 one-beat burst stored");
        s_read(11'h061, 8'h99, "R5 byte past length ignored");

        // Twenty beats: length needs byte 3
        d = {};
        for (int i = 0; i < 20; i++) d.push_back(8'(i * 3 + 1));
        b_write(11'h080, 1'b0, d, 8'hFF, "R1 long burst write");
        b_read(11'h080, 1'b0, d, "R1 long burst read");

        // Frame aborted inside the header
        s_write(11'h0C3, 8'h3C, "R9 aborted write", ID, 1'b0, 4);
        s_read(11'h0C3, 8'hA5, "R9 abort leaves register and next frame decodes");

        wait_clk(20);
        while (ex_x.size() > 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL %s: got no byte at position %0d expected %02h",
                     ex_t[0], ex_p[0], ex_v[0]);
            void'(ex_x.pop_front());
            void'(ex_p.pop_front());
            void'(ex_v.pop_front());
            void'(ex_t.pop_front());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule